// File: doc/BRIEF.md
# DMA Channel Control and Status Register Block

This block holds the software-visible registers of a single DMA channel: a channel status word, a write-only control port that edits that status word, the descriptor command pointer, and three condition-select registers used by the channel sequencer for interrupt, branch and wait decisions. Software reaches all of them over a plain 32-bit register bus with a write strobe, a word address and a combinational read path.

A control write never overwrites the status word wholesale. Its upper half is a bit mask and its lower half supplies new values, so only the selected bits change and software can flip one bit without a read-modify-write. The write then takes effect on the rest of the channel. Starting or stopping the run bit raises or drops the active flag. A flush bit written to one sends a one-cycle flush request to the attached device. Any control write that alters the status word sends a one-cycle kick to the sequencer so it re-evaluates whether it can run. A command pointer write is refused while the channel is active; otherwise the pointer is stored aligned to 16 bytes and a one-cycle descriptor fetch request is issued. The sequencer reports halt, kill and branch outcomes back through dedicated inputs.

Word addresses: 0 control (reads return status), 1 status, 2 command pointer, 3 interrupt select, 4 branch select, 5 wait select; 6 and 7 read zero and ignore writes.

Top module: `chan_ctrl_regs`

## Requirements
- R1: Status bits are run 15, pause 14, flush 13, wake 12, dead 11, active 10, branch-taken 8, device status 7:0 (bit 9 and bits above 15 read 0). A control write (address 0) changes a status bit among run, pause, flush, wake and device status only when its mask bit wdata[16+bit] is 1, taking the value wdata[bit].
- R2: A control write whose run mask bit (wdata[31]) is 1 sets active to the written run value wdata[15].
- R3: Dead, active, branch-taken and bit 9 are never taken from the value half of a control write, whatever the mask.
- R4: A control write with wdata[29] and wdata[13] both 1 sets the flush status bit and pulses flushReq for exactly the next cycle.
- R5: kickReq pulses for one cycle after a control write that changed the status word, and stays low after one that left it unchanged.
- R6: A command pointer write (address 2) made while active is 1 leaves cmdPtr unchanged and raises no fetchReq.
- R7: A command pointer write made while active is 0 stores wdata with bits 3:0 cleared and pulses fetchReq for the next cycle.
- R8: regRdata shows status (zero-extended) at addresses 0 and 1, cmdPtr at 2, the select registers exactly as written at 3, 4 and 5, and 0 at 6 and 7; writes to addresses 1, 6 and 7 change nothing.
- R9: In the same cycle as any control write, seqKill sets dead and clears active, seqHalt clears active, and seqBranch loads branch-taken from seqBranchTaken; these act after the control write.
- R10: After reset, status, command pointer, select registers and all request pulses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Word address of the access |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for regAddr, combinational |
| seqHalt | input | 1 | Sequencer stopped: clear active |
| seqKill | input | 1 | Sequencer error: set dead, clear active |
| seqBranch | input | 1 | Load branch-taken flag |
| seqBranchTaken | input | 1 | Value for branch-taken flag |
| statusOut | output | 16 | Current status word |
| cmdPtr | output | 32 | Current command pointer |
| intSel | output | 32 | Interrupt condition select |
| branchSel | output | 32 | Branch condition select |
| waitSel | output | 32 | Wait condition select |
| flushReq | output | 1 | One-cycle flush request to the device |
| kickReq | output | 1 | One-cycle sequencer re-check request |
| fetchReq | output | 1 | One-cycle descriptor fetch request |

## Verification
The assertions assume the sequencer inputs are clean levels sampled at the clock edge and that they may coincide with any register write, so their checks of masked holding and run-to-active carve out cycles where a halt or kill also arrives. The stimulus drives every input at the falling edge, draws addresses over the whole 3-bit space including the unused slots, and keeps kill rare so that the dead flag does not dominate the run while the other sequencer events stay frequent enough to collide with control writes.

// File: rtl/chan_reg_pkg.sv
package chan_reg_pkg;
  localparam int ST_W     = 16;
  localparam int B_RUN    = 15;
  localparam int B_PAUSE  = 14;
  localparam int B_FLUSH  = 13;
  localparam int B_WAKE   = 12;
  localparam int B_DEAD   = 11;
  localparam int B_ACTIVE = 10;
  localparam int B_BRANCH = 8;
  // bits a control write may touch: run, pause, flush, wake, device status
  localparam logic [ST_W-1:0] WRITABLE = 16'hF0FF;

  localparam int CTL_ADDR  = 0;
  localparam int STAT_ADDR = 1;
  localparam int PTR_ADDR  = 2;
  localparam int SEL_BASE  = 3;
  localparam int NUM_SEL   = 3;

  typedef struct packed {
    logic               ctlWr;
    logic               ptrWr;
    logic [NUM_SEL-1:0] selWr;
  } regStrobe_t;
endpackage

// File: rtl/chan_reg_ctrl.sv
module chan_reg_ctrl
  import chan_reg_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              chanActive,
  output regStrobe_t        strb
);
  logic ptrHit;

  assign ptrHit     = wrEn && (addr == ADDR_W'(PTR_ADDR));
  assign strb.ctlWr = wrEn && (addr == ADDR_W'(CTL_ADDR));
  assign strb.ptrWr = ptrHit && !chanActive;

  for (genvar g = 0; g < NUM_SEL; g++) begin : gSelDec
    assign strb.selWr[g] = wrEn && (addr == ADDR_W'(SEL_BASE + g));
  end
endmodule

// File: rtl/chan_reg_data.sv
module chan_reg_data
  import chan_reg_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 3,
  parameter int PTR_LSB = 4
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  regStrobe_t                     strb,
  input  logic [DATA_W-1:0]              wdata,
  input  logic [ADDR_W-1:0]              addr,
  input  logic                           seqHalt,
  input  logic                           seqKill,
  input  logic                           seqBranch,
  input  logic                           seqBranchTaken,
  output logic [ST_W-1:0]                status,
  output logic [DATA_W-1:0]              cmdPtr,
  output logic [NUM_SEL-1:0][DATA_W-1:0] selRegs,
  output logic [DATA_W-1:0]              rdata,
  output logic                           flushReq,
  output logic                           kickReq,
  output logic                           fetchReq
);
  localparam int MASK_LO = ST_W;

  logic [ST_W-1:0] wrMask;
  logic [ST_W-1:0] wrVal;
  logic [ST_W-1:0] ctlStatus;
  logic [ST_W-1:0] nextStatus;
  logic            runMasked;
  logic            flushHit;

  assign wrMask    = wdata[MASK_LO +: ST_W] & WRITABLE;
  assign wrVal     = wdata[ST_W-1:0];
  assign runMasked = wdata[MASK_LO + B_RUN];
  assign flushHit  = strb.ctlWr && wdata[MASK_LO + B_FLUSH] && wdata[B_FLUSH];

  // control write result, before sequencer events
  always_comb begin
    ctlStatus = (status & ~wrMask) | (wrVal & wrMask);
    if (runMasked) ctlStatus[B_ACTIVE] = wrVal[B_RUN];
  end

  always_comb begin
    nextStatus = strb.ctlWr ? ctlStatus : status;
    if (seqBranch) nextStatus[B_BRANCH] = seqBranchTaken;
    if (seqHalt)   nextStatus[B_ACTIVE] = 1'b0;
    if (seqKill) begin
      nextStatus[B_DEAD]   = 1'b1;
      nextStatus[B_ACTIVE] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      status   <= '0;
      flushReq <= 1'b0;
      kickReq  <= 1'b0;
    end else begin
      status   <= nextStatus;
      flushReq <= flushHit;
      kickReq  <= strb.ctlWr && (ctlStatus != status);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdPtr   <= '0;
      fetchReq <= 1'b0;
    end else begin
      fetchReq <= strb.ptrWr;
      if (strb.ptrWr) cmdPtr <= {wdata[DATA_W-1:PTR_LSB], PTR_LSB'(0)};
    end
  end

  for (genvar g = 0; g < NUM_SEL; g++) begin : gSel
    always_ff @(posedge clk) begin
      if (!rstN)             selRegs[g] <= '0;
      else if (strb.selWr[g]) selRegs[g] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(CTL_ADDR) || addr == ADDR_W'(STAT_ADDR))
      rdata = DATA_W'(status);
    else if (addr == ADDR_W'(PTR_ADDR))
      rdata = cmdPtr;
    for (int i = 0; i < NUM_SEL; i++)
      if (addr == ADDR_W'(SEL_BASE + i)) rdata = selRegs[i];
  end

  // unmasked pause keeps its value across a control write
  assert_masked_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ctlWr && !wdata[MASK_LO + B_PAUSE]) |=> (status[B_PAUSE] == $past(status[B_PAUSE])));

  assert_run_active_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ctlWr && runMasked && wrVal[B_RUN] && !seqHalt && !seqKill) |=> status[B_ACTIVE]);

  assert_no_dead_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ctlWr && !seqKill && !status[B_DEAD]) |=> !status[B_DEAD]);

  assert_flush_req_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ctlWr && wdata[MASK_LO + B_FLUSH] && wdata[B_FLUSH]) |=> (flushReq && status[B_FLUSH]));

  assert_fetch_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.ptrWr |=> (fetchReq && cmdPtr[DATA_W-1:PTR_LSB] == $past(wdata[DATA_W-1:PTR_LSB])));

  assert_kill_R9: assert property (@(posedge clk) disable iff (!rstN)
    seqKill |=> (status[B_DEAD] && !status[B_ACTIVE]));
endmodule

// File: rtl/chan_ctrl_regs.sv
module chan_ctrl_regs
  import chan_reg_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 3,
  parameter int PTR_LSB = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              seqHalt,
  input  logic              seqKill,
  input  logic              seqBranch,
  input  logic              seqBranchTaken,
  output logic [ST_W-1:0]   statusOut,
  output logic [DATA_W-1:0] cmdPtr,
  output logic [DATA_W-1:0] intSel,
  output logic [DATA_W-1:0] branchSel,
  output logic [DATA_W-1:0] waitSel,
  output logic              flushReq,
  output logic              kickReq,
  output logic              fetchReq
);
  regStrobe_t                     strb;
  logic [NUM_SEL-1:0][DATA_W-1:0] selRegs;

  chan_reg_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .wrEn       (regWrEn),
    .addr       (regAddr),
    .chanActive (statusOut[B_ACTIVE]),
    .strb       (strb)
  );

  chan_reg_data #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .PTR_LSB(PTR_LSB)) i_data (
    .clk            (clk),
    .rstN           (rstN),
    .strb           (strb),
    .wdata          (regWdata),
    .addr           (regAddr),
    .seqHalt        (seqHalt),
    .seqKill        (seqKill),
    .seqBranch      (seqBranch),
    .seqBranchTaken (seqBranchTaken),
    .status         (statusOut),
    .cmdPtr         (cmdPtr),
    .selRegs        (selRegs),
    .rdata          (regRdata),
    .flushReq       (flushReq),
    .kickReq        (kickReq),
    .fetchReq       (fetchReq)
  );

  assign intSel    = selRegs[0];
  assign branchSel = selRegs[1];
  assign waitSel   = selRegs[2];

  assert_ptr_lock_R6: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_W'(PTR_ADDR) && statusOut[B_ACTIVE]) |=> ($stable(cmdPtr) && !fetchReq));
endmodule

// File: tb/test_chan_ctrl_regs.sv
module test_chan_ctrl_regs;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        seqHalt = 1'b0, seqKill = 1'b0, seqBranch = 1'b0, seqBranchTaken = 1'b0;
  logic [15:0] statusOut;
  logic [31:0] cmdPtr, intSel, branchSel, waitSel;
  logic        flushReq, kickReq, fetchReq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [15:0] mStatus;
  logic [31:0] mPtr;
  logic [31:0] mSel [3];

  always #4 clk = ~clk;

  chan_ctrl_regs i_chan_ctrl_regs (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .seqHalt(seqHalt), .seqKill(seqKill), .seqBranch(seqBranch),
    .seqBranchTaken(seqBranchTaken), .statusOut(statusOut), .cmdPtr(cmdPtr),
    .intSel(intSel), .branchSel(branchSel), .waitSel(waitSel),
    .flushReq(flushReq), .kickReq(kickReq), .fetchReq(fetchReq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] ctlFn(logic [15:0] s, logic [31:0] w);
    logic [15:0] m;
    logic [15:0] n;
    m = w[31:16] & 16'hF0FF;
    n = (s & ~m) | (w[15:0] & m);
    if (w[31]) n[10] = w[15];
    return n;
  endfunction

  function automatic logic [31:0] readFn(logic [2:0] a);
    case (a)
      3'd0, 3'd1: return {16'h0, mStatus};
      3'd2:       return mPtr;
      3'd3:       return mSel[0];
      3'd4:       return mSel[1];
      3'd5:       return mSel[2];
      default:    return 32'h0;
    endcase
  endfunction

  task automatic step(logic wr, logic [2:0] a, logic [31:0] w,
                      logic h, logic k, logic b, logic bt);
    logic [15:0] nSt;
    logic        fE, kE, pE;
    @(negedge clk);
    regWrEn = wr; regAddr = a; regWdata = w;
    seqHalt = h; seqKill = k; seqBranch = b; seqBranchTaken = bt;
    #1;
    check("R8 read path", regRdata, readFn(a));
    nSt = mStatus;
    fE = 1'b0; kE = 1'b0; pE = 1'b0;
    if (wr && a == 3'd0) begin
      nSt = ctlFn(mStatus, w);
      kE  = (nSt != mStatus);
      fE  = w[29] && w[13];
    end
    if (b) nSt[8] = bt;
    if (h) nSt[10] = 1'b0;
    if (k) begin nSt[11] = 1'b1; nSt[10] = 1'b0; end
    if (wr && a == 3'd2 && !mStatus[10]) begin
      mPtr = {w[31:4], 4'h0};
      pE = 1'b1;
    end
    if (wr && a >= 3'd3 && a <= 3'd5) mSel[a - 3'd3] = w;
    mStatus = nSt;
    @(posedge clk); #1;
    check("R1 status", {16'h0, statusOut}, {16'h0, mStatus});
    check("R6/R7 cmdPtr", cmdPtr, mPtr);
    check("R7 fetchReq", {31'h0, fetchReq}, {31'h0, pE});
    check("R4 flushReq", {31'h0, flushReq}, {31'h0, fE});
    check("R5 kickReq", {31'h0, kickReq}, {31'h0, kE});
    check("R8 intSel", intSel, mSel[0]);
    check("R8 branchSel", branchSel, mSel[1]);
    check("R8 waitSel", waitSel, mSel[2]);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    void'($urandom(32'd20240611));
    mStatus = '0; mPtr = '0;
    for (int i = 0; i < 3; i++) mSel[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #1;
    // R10 reset state
    check("R10 status", {16'h0, statusOut}, 32'h0);
    check("R10 cmdPtr", cmdPtr, 32'h0);
    check("R10 selects", intSel | branchSel | waitSel, 32'h0);
    check("R10 pulses", {29'h0, flushReq, kickReq, fetchReq}, 32'h0);

    step(1, 3'd0, 32'h8000_8000, 0, 0, 0, 0);   // set run
    check("R2 run raises active", {31'h0, statusOut[10]}, 32'h1);
    step(1, 3'd2, 32'h1234_5677, 0, 0, 0, 0);   // locked
    check("R6 ptr locked", cmdPtr, 32'h0);
    step(1, 3'd0, 32'h0D00_0000, 0, 0, 0, 0);   // try clearing active/dead/bt
    check("R3 active kept", {31'h0, statusOut[10]}, 32'h1);
    step(1, 3'd0, 32'h8000_0000, 0, 0, 0, 0);   // clear run
    check("R2 run clear drops active", {31'h0, statusOut[10]}, 32'h0);
    step(1, 3'd0, 32'h0F00_0F00, 0, 0, 0, 0);   // try setting dead/active/bt/bit9
    check("R3 protected bits", {16'h0, statusOut & 16'h0F00}, 32'h0);
    check("R5 no change no kick", {31'h0, kickReq}, 32'h0);
    step(1, 3'd2, 32'hABCD_EF1F, 0, 0, 0, 0);
    check("R7 aligned ptr", cmdPtr, 32'hABCD_EF10);
    step(1, 3'd0, 32'h2000_2000, 0, 0, 0, 0);
    check("R4 flush pulse", {31'h0, flushReq}, 32'h1);
    step(1, 3'd0, 32'h8000_8000, 1, 0, 1, 1);   // run with halt in same cycle
    check("R9 halt after write", {16'h0, statusOut & 16'h8500}, 32'h8100);
    step(1, 3'd6, 32'hFFFF_FFFF, 0, 1, 0, 0);   // kill, unused address
    check("R9 kill", {16'h0, statusOut & 16'h0C00}, 32'h0800);
    step(0, 3'd7, 32'h0, 0, 0, 0, 0);
    check("R8 unused reads zero", regRdata, 32'h0);

    for (int n = 0; n < 3000; n++) begin
      logic [2:0] a;
      a = 3'($urandom % 8);
      step(($urandom % 2) == 0, a, $urandom,
           ($urandom % 16) == 0, ($urandom % 200) == 0,
           ($urandom % 8) == 0, $urandom % 2);
    end
    finishRun();
  end
endmodule